// File: doc/BRIEF.md
# Address Decoding Window Unit

This block turns a 32-bit physical address issued by a data-moving engine into a memory target. It holds eight programmable windows. Each window has a base register and a size register with 64 KB granularity. The base register also carries the target ID and the attribute byte that the window delivers. Each of two request ports has its own enable word, which switches individual windows on for that port and grants each one read and/or write access.

Every cycle, each port may present one request made of an address and a direction. All eight windows are compared in parallel, and the lowest-numbered matching window is chosen. The result appears one cycle later as one of three outcomes:

- an accepted access, carrying the window's target and attribute;
- an address-miss error;
- a protection error.

On either error, the offending address is latched for the port. Software programs the windows over a small register bus. Word indices above the defined registers stand for the remap and override controls: they read as zero and writing them changes nothing.

Top module: `addr_window_unit`

## Requirements
- R1: After reset every register reads zero, no response or error is flagged on either port, and both latched error addresses are zero.
- R2: Register word index i (0..7) is window i's base, index 8+i is window i's size, index 16 is port 0's enable word and index 17 is port 1's enable word. A write takes effect at the clock edge, and read data appears on reg_rd_data one cycle after reg_rd_idx is presented.
- R3: Indices 18..31 (remap and override controls) always read zero, and writing them has no effect on any decode.
- R4: An address hits window i when (addr[31:16] & ~size_i[31:16]) == (base_i[31:16] & ~size_i[31:16]) and window i is enabled for that port.
- R5: When several windows hit, the lowest-numbered one is selected.
- R6: Bit i of a port's enable word enables window i for that port only. A disabled window never hits.
- R7: Enable-word bits [16+2i] and [17+2i] grant read and write access to window i respectively. A hit whose direction lacks the grant gives a protection error (rsp_prot) instead of an accepted access.
- R8: A request that hits no window gives an address-miss error (rsp_miss).
- R9: rsp_miss and rsp_prot are single-cycle pulses. The port's err_addr captures the address of the erroring request and holds it until the next error on that port.
- R10: A request is answered exactly one cycle later with exactly one of rsp_ok, rsp_miss or rsp_prot set. On rsp_ok, rsp_win gives the window index, rsp_target gives base bits 3:0 and rsp_attr gives base bits 15:8. Otherwise these three fields are zero.
- R11: The two ports decode independently and may issue requests in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 5 | Register word index for write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 5 | Register word index for read |
| reg_rd_data | output | 32 | Read data, one cycle after index |
| req_valid | input | 2 | Request valid, one bit per port |
| req_write | input | 2 | Request is a write, one bit per port |
| req_addr | input | 64 | Request address, port p in bits [32p+31:32p] |
| rsp_valid | output | 2 | Response valid per port |
| rsp_ok | output | 2 | Access accepted per port |
| rsp_miss | output | 2 | Address-miss error pulse per port |
| rsp_prot | output | 2 | Protection error pulse per port |
| rsp_win | output | 6 | Selected window, 3 bits per port |
| rsp_target | output | 8 | Target ID, 4 bits per port |
| rsp_attr | output | 16 | Attribute, 8 bits per port |
| err_addr | output | 64 | Latched error address, 32 bits per port |

## Verification
The assertions assume the following about the inputs:
- reset is held low for at least one clock edge before any request arrives;
- req_addr is meaningful only while its req_valid bit is high;
- register contents are not rewritten in the same cycle as a request whose decode depends on them.

The stimulus meets these assumptions by separating programming phases from request sweeps. Each request pair is followed by an idle cycle, so the single-cycle error pulse and the held error address can both be observed. The sweeps cover two window layouts: one with contiguous windows, and one with non-contiguous masks and a catch-all window. Between the two, the reserved indices are written with all ones.

// File: rtl/awu_pkg.sv
package awu_pkg;
    localparam int AWU_WIN      = 8;
    localparam int AWU_PORT     = 2;
    localparam int AWU_ADDR_W   = 32;
    localparam int AWU_DATA_W   = 32;
    localparam int AWU_TGT_W    = 4;
    localparam int AWU_ATTR_W   = 8;
    localparam int AWU_ATTR_LSB = 8;
    localparam int AWU_GRAN     = 16;
    localparam int AWU_IDX_W    = 5;
    localparam int AWU_ACC_RD   = 0;
    localparam int AWU_ACC_WR   = 1;
endpackage

// File: rtl/awu_regfile.sv
module awu_regfile
    import awu_pkg::*;
#(
    parameter int NUM_WIN  = AWU_WIN,
    parameter int NUM_PORT = AWU_PORT,
    parameter int DATA_W   = AWU_DATA_W,
    parameter int IDX_W    = AWU_IDX_W,
    parameter int GRAN     = AWU_GRAN,
    parameter int TGT_W    = AWU_TGT_W,
    parameter int ATTR_W   = AWU_ATTR_W,
    parameter int ATTR_LSB = AWU_ATTR_LSB,
    localparam int HI_W    = DATA_W - GRAN,
    localparam int ACC_LSB = DATA_W - 2 * NUM_WIN
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic [IDX_W-1:0]                      rd_idx,
    output logic [DATA_W-1:0]                     rd_data,
    output logic [NUM_WIN-1:0][HI_W-1:0]          win_base,
    output logic [NUM_WIN-1:0][HI_W-1:0]          win_size,
    output logic [NUM_WIN-1:0][TGT_W-1:0]         win_tgt,
    output logic [NUM_WIN-1:0][ATTR_W-1:0]        win_attr,
    output logic [NUM_PORT-1:0][NUM_WIN-1:0]      port_en,
    output logic [NUM_PORT-1:0][2*NUM_WIN-1:0]    port_acc
);

    typedef struct packed {
        logic [NUM_WIN-1:0][DATA_W-1:0]  base;
        logic [NUM_WIN-1:0][DATA_W-1:0]  size;
        logic [NUM_PORT-1:0][DATA_W-1:0] en;
        logic [DATA_W-1:0]               rd;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d    = rf_q;
        rf_d.rd = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (wr_en && wr_idx == IDX_W'(i))           rf_d.base[i] = wr_data;
            if (wr_en && wr_idx == IDX_W'(NUM_WIN + i)) rf_d.size[i] = wr_data;
            if (rd_idx == IDX_W'(i))                    rf_d.rd = rf_q.base[i];
            if (rd_idx == IDX_W'(NUM_WIN + i))          rf_d.rd = rf_q.size[i];
        end
        for (int p = 0; p < NUM_PORT; p++) begin
            if (wr_en && wr_idx == IDX_W'(2 * NUM_WIN + p)) rf_d.en[p] = wr_data;
            if (rd_idx == IDX_W'(2 * NUM_WIN + p))          rf_d.rd = rf_q.en[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign rd_data = rf_q.rd;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign win_base[i] = rf_q.base[i][DATA_W-1 -: HI_W];
        assign win_size[i] = rf_q.size[i][DATA_W-1 -: HI_W];
        assign win_tgt[i]  = rf_q.base[i][TGT_W-1:0];
        assign win_attr[i] = rf_q.base[i][ATTR_LSB +: ATTR_W];
    end

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        assign port_en[p]  = rf_q.en[p][NUM_WIN-1:0];
        assign port_acc[p] = rf_q.en[p][ACC_LSB +: 2*NUM_WIN];
    end

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_idx) >= IDX_W'(2 * NUM_WIN + NUM_PORT)) |-> (rd_data == '0)) // R3
        else $error("reserved index returned nonzero data");

endmodule

// File: rtl/awu_match.sv
module awu_match
    import awu_pkg::*;
#(
    parameter int NUM_WIN  = AWU_WIN,
    parameter int ADDR_W   = AWU_ADDR_W,
    parameter int GRAN     = AWU_GRAN,
    parameter int TGT_W    = AWU_TGT_W,
    parameter int ATTR_W   = AWU_ATTR_W,
    localparam int HI_W    = ADDR_W - GRAN,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WIN-1:0][HI_W-1:0]     win_base,
    input  logic [NUM_WIN-1:0][HI_W-1:0]     win_size,
    input  logic [NUM_WIN-1:0][TGT_W-1:0]    win_tgt,
    input  logic [NUM_WIN-1:0][ATTR_W-1:0]   win_attr,
    input  logic [NUM_WIN-1:0]               win_en,
    input  logic [2*NUM_WIN-1:0]             win_acc,
    input  logic                             req_valid,
    input  logic                             req_write,
    input  logic [ADDR_W-1:0]                req_addr,
    output logic                             rsp_valid,
    output logic                             rsp_ok,
    output logic                             rsp_miss,
    output logic                             rsp_prot,
    output logic [WIN_W-1:0]                 rsp_win,
    output logic [TGT_W-1:0]                 rsp_target,
    output logic [ATTR_W-1:0]                rsp_attr,
    output logic [ADDR_W-1:0]                err_addr
);

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic              miss;
        logic              prot;
        logic [WIN_W-1:0]  win;
        logic [TGT_W-1:0]  tgt;
        logic [ATTR_W-1:0] attr;
        logic [ADDR_W-1:0] eaddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [NUM_WIN-1:0] hit;
    logic [WIN_W-1:0]   sel;
    logic               any_hit;
    logic               allowed;
    logic [1:0]         sel_acc;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        logic [HI_W-1:0] keep;
        assign keep   = ~win_size[i];
        assign hit[i] = win_en[i] &&
                        ((req_addr[ADDR_W-1 -: HI_W] & keep) == (win_base[i] & keep));
    end

    always_comb begin
        sel = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) sel = WIN_W'(i);
        end
    end

    assign any_hit = |hit;
    assign sel_acc = win_acc[2*sel +: 2];
    assign allowed = req_write ? sel_acc[AWU_ACC_WR] : sel_acc[AWU_ACC_RD];

    always_comb begin
        rsp_d       = '0;
        rsp_d.eaddr = rsp_q.eaddr;
        rsp_d.valid = req_valid;
        rsp_d.ok    = req_valid && any_hit && allowed;
        rsp_d.miss  = req_valid && !any_hit;
        rsp_d.prot  = req_valid && any_hit && !allowed;
        if (rsp_d.ok) begin
            rsp_d.win  = sel;
            rsp_d.tgt  = win_tgt[sel];
            rsp_d.attr = win_attr[sel];
        end
        if (rsp_d.miss || rsp_d.prot) rsp_d.eaddr = req_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_ok     = rsp_q.ok;
    assign rsp_miss   = rsp_q.miss;
    assign rsp_prot   = rsp_q.prot;
    assign rsp_win    = rsp_q.win;
    assign rsp_target = rsp_q.tgt;
    assign rsp_attr   = rsp_q.attr;
    assign err_addr   = rsp_q.eaddr;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_ok, rsp_miss, rsp_prot}) == 1)) // R10
        else $error("response without exactly one outcome");

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) // R10
        else $error("request not answered next cycle");

    AST_IDLE_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_miss && !rsp_prot)) // R9
        else $error("error flagged without a request");

    AST_ERR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_miss || rsp_prot) |-> $stable(err_addr)) // R9
        else $error("error address moved without an error");

    AST_MISS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (hit == '0)) |=> (rsp_miss && err_addr == $past(req_addr))) // R8
        else $error("miss not reported with its address");

    AST_FIELDS_ZERO_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ok |-> (rsp_win == '0 && rsp_target == '0 && rsp_attr == '0)) // R10
        else $error("result fields nonzero without acceptance");

endmodule

// File: rtl/addr_window_unit.sv
module addr_window_unit
    import awu_pkg::*;
#(
    parameter int NUM_WIN  = AWU_WIN,
    parameter int NUM_PORT = AWU_PORT,
    parameter int ADDR_W   = AWU_ADDR_W,
    parameter int IDX_W    = AWU_IDX_W,
    parameter int TGT_W    = AWU_TGT_W,
    parameter int ATTR_W   = AWU_ATTR_W,
    localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int HI_W    = ADDR_W - AWU_GRAN
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr_en,
    input  logic [IDX_W-1:0]             reg_wr_idx,
    input  logic [ADDR_W-1:0]            reg_wr_data,
    input  logic [IDX_W-1:0]             reg_rd_idx,
    output logic [ADDR_W-1:0]            reg_rd_data,
    input  logic [NUM_PORT-1:0]          req_valid,
    input  logic [NUM_PORT-1:0]          req_write,
    input  logic [NUM_PORT*ADDR_W-1:0]   req_addr,
    output logic [NUM_PORT-1:0]          rsp_valid,
    output logic [NUM_PORT-1:0]          rsp_ok,
    output logic [NUM_PORT-1:0]          rsp_miss,
    output logic [NUM_PORT-1:0]          rsp_prot,
    output logic [NUM_PORT*WIN_W-1:0]    rsp_win,
    output logic [NUM_PORT*TGT_W-1:0]    rsp_target,
    output logic [NUM_PORT*ATTR_W-1:0]   rsp_attr,
    output logic [NUM_PORT*ADDR_W-1:0]   err_addr
);

    logic [NUM_WIN-1:0][HI_W-1:0]        win_base;
    logic [NUM_WIN-1:0][HI_W-1:0]        win_size;
    logic [NUM_WIN-1:0][TGT_W-1:0]       win_tgt;
    logic [NUM_WIN-1:0][ATTR_W-1:0]      win_attr;
    logic [NUM_PORT-1:0][NUM_WIN-1:0]    port_en;
    logic [NUM_PORT-1:0][2*NUM_WIN-1:0]  port_acc;

    awu_regfile #(
        .NUM_WIN  (NUM_WIN),
        .NUM_PORT (NUM_PORT),
        .DATA_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .GRAN     (AWU_GRAN),
        .TGT_W    (TGT_W),
        .ATTR_W   (ATTR_W),
        .ATTR_LSB (AWU_ATTR_LSB)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_idx   (reg_wr_idx),
        .wr_data  (reg_wr_data),
        .rd_idx   (reg_rd_idx),
        .rd_data  (reg_rd_data),
        .win_base (win_base),
        .win_size (win_size),
        .win_tgt  (win_tgt),
        .win_attr (win_attr),
        .port_en  (port_en),
        .port_acc (port_acc)
    );

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        awu_match #(
            .NUM_WIN (NUM_WIN),
            .ADDR_W  (ADDR_W),
            .GRAN    (AWU_GRAN),
            .TGT_W   (TGT_W),
            .ATTR_W  (ATTR_W)
        ) u_match (
            .clk        (clk),
            .rst_n      (rst_n),
            .win_base   (win_base),
            .win_size   (win_size),
            .win_tgt    (win_tgt),
            .win_attr   (win_attr),
            .win_en     (port_en[p]),
            .win_acc    (port_acc[p]),
            .req_valid  (req_valid[p]),
            .req_write  (req_write[p]),
            .req_addr   (req_addr[p*ADDR_W +: ADDR_W]),
            .rsp_valid  (rsp_valid[p]),
            .rsp_ok     (rsp_ok[p]),
            .rsp_miss   (rsp_miss[p]),
            .rsp_prot   (rsp_prot[p]),
            .rsp_win    (rsp_win[p*WIN_W +: WIN_W]),
            .rsp_target (rsp_target[p*TGT_W +: TGT_W]),
            .rsp_attr   (rsp_attr[p*ATTR_W +: ATTR_W]),
            .err_addr   (err_addr[p*ADDR_W +: ADDR_W])
        );
    end

endmodule

// File: tb/addr_window_unit_test.sv
`timescale 1ns/1ps
module addr_window_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_wr_idx = '0;
    logic [31:0] reg_wr_data = '0;
    logic [4:0]  reg_rd_idx = '0;
    logic [31:0] reg_rd_data;
    logic [1:0]  req_valid = '0;
    logic [1:0]  req_write = '0;
    logic [63:0] req_addr = '0;
    logic [1:0]  rsp_valid, rsp_ok, rsp_miss, rsp_prot;
    logic [5:0]  rsp_win;
    logic [7:0]  rsp_target;
    logic [15:0] rsp_attr;
    logic [63:0] err_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] mbase [8];
    logic [31:0] msize [8];
    logic [31:0] men   [2];
    logic [31:0] merr  [2];

    always #2 clk = ~clk;

    addr_window_unit uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_miss(rsp_miss), .rsp_prot(rsp_prot),
        .rsp_win(rsp_win), .rsp_target(rsp_target), .rsp_attr(rsp_attr),
        .err_addr(err_addr)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic reg_write(int idx, logic [31:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_idx  = 5'(idx);
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        if (idx < 8)       mbase[idx]    = data;
        else if (idx < 16) msize[idx-8]  = data;
        else if (idx < 18) men[idx-16]   = data;
    endtask

    task automatic reg_check(string tag, int idx, logic [31:0] exp);
        @(negedge clk);
        reg_rd_idx = 5'(idx);
        @(negedge clk);
        check(tag, {32'd0, reg_rd_data}, {32'd0, exp});
    endtask

    // expected {ok, miss, prot, win[2:0], target[3:0], attr[7:0]}
    function automatic logic [17:0] model(int p, logic [31:0] a, bit wr);
        int sel = -1;
        logic [15:0] keep;
        logic [1:0]  acc;
        for (int i = 7; i >= 0; i--) begin
            keep = ~msize[i][31:16];
            if (men[p][i] && ((a[31:16] & keep) == (mbase[i][31:16] & keep))) sel = i;
        end
        if (sel < 0) return {3'b010, 15'd0};
        acc = men[p][16 + 2*sel +: 2];
        if (!(wr ? acc[1] : acc[0])) return {3'b001, 15'd0};
        return {3'b100, 3'(sel), mbase[sel][3:0], mbase[sel][15:8]};
    endfunction

    task automatic request_pair(logic [31:0] a0, bit w0, logic [31:0] a1, bit w1);
        logic [17:0] e0, e1;
        e0 = model(0, a0, w0);
        e1 = model(1, a1, w1);
        @(negedge clk);
        req_valid = 2'b11;
        req_write = {w1, w0};
        req_addr  = {a1, a0};
        @(negedge clk);
        req_valid = 2'b00;
        if (e0[16] || e0[15]) merr[0] = a0;
        if (e1[16] || e1[15]) merr[1] = a1;
        check("R4 R5 R6 R7 R8 R10 R11 port0 outcome",
              {45'd0, rsp_valid[0], rsp_ok[0], rsp_miss[0], rsp_prot[0], rsp_win[2:0],
               rsp_target[3:0], rsp_attr[7:0]}, {45'd0, 1'b1, e0});
        check("R4 R5 R6 R7 R8 R10 R11 port1 outcome",
              {45'd0, rsp_valid[1], rsp_ok[1], rsp_miss[1], rsp_prot[1], rsp_win[5:3],
               rsp_target[7:4], rsp_attr[15:8]}, {45'd0, 1'b1, e1});
        check("R9 error addresses", err_addr, {merr[1], merr[0]});
        @(negedge clk);
        check("R9 pulse ends", {58'd0, rsp_valid, rsp_miss, rsp_prot}, 64'd0);
        check("R9 error address held", err_addr, {merr[1], merr[0]});
    endtask

    task automatic sweep();
        logic [15:0] h0, h1;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 68; i++) begin
                h0 = (i < 64) ? 16'(i) : 16'hFFFC + 16'(i - 64);
                h1 = 16'((i * 5 + 7) % 64);
                request_pair({h0, 16'(i * 37 + 11)}, bit'(k ^ (i & 1)),
                             {h1, 16'(i * 91 + 3)}, bit'(k ^ ((i >> 1) & 1)));
            end
        end
    endtask

    function automatic logic [31:0] acc_word(logic [7:0] en, logic [1:0] a [8]);
        logic [31:0] w = {24'd0, en};
        for (int i = 0; i < 8; i++) w[16 + 2*i +: 2] = a[i];
        return w;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [1:0] a0 [8];
        logic [1:0] a1 [8];
        for (int i = 0; i < 8; i++) begin mbase[i] = '0; msize[i] = '0; end
        men[0] = '0; men[1] = '0; merr[0] = '0; merr[1] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 no response after reset",
              {56'd0, rsp_valid, rsp_ok, rsp_miss, rsp_prot}, 64'd0);
        check("R1 error address zero", err_addr, 64'd0);
        for (int i = 0; i < 32; i++) reg_check("R1 register zero", i, 32'd0);

        // configuration one: contiguous windows, one overlap
        reg_write(0,  32'h0000_10A1);
        reg_write(1,  32'h0004_21B2);
        reg_write(2,  32'h0010_32C3);
        reg_write(3,  32'h0012_43D4);
        reg_write(4,  32'h0020_54E5);
        reg_write(5,  32'h0028_65F6);
        reg_write(6,  32'h0030_7607);
        reg_write(7,  32'h0034_8718);
        reg_write(8,  32'h0003_1234);
        reg_write(9,  32'h0003_0000);
        reg_write(10, 32'h000F_0001);
        reg_write(11, 32'h0000_FFFF);
        reg_write(12, 32'h0007_0000);
        reg_write(13, 32'h0007_0000);
        reg_write(14, 32'h0001_0000);
        reg_write(15, 32'h0003_0000);
        a0 = '{2'd3, 2'd3, 2'd3, 2'd3, 2'd1, 2'd3, 2'd0, 2'd2};
        a1 = '{2'd1, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3};
        reg_write(16, acc_word(8'hDF, a0));
        reg_write(17, acc_word(8'hFF, a1));

        // R2 readback
        for (int i = 0; i < 8; i++) reg_check("R2 base readback", i, mbase[i]);
        for (int i = 0; i < 8; i++) reg_check("R2 size readback", 8 + i, msize[i]);
        reg_check("R2 port0 enable readback", 16, men[0]);
        reg_check("R2 port1 enable readback", 17, men[1]);

        sweep();

        // R3 reserved indices: write ones, read zero
        for (int i = 18; i < 32; i++) reg_write(i, 32'hFFFF_FFFF);
        for (int i = 18; i < 32; i++) reg_check("R3 reserved reads zero", i, 32'd0);
        reg_check("R3 enable unchanged", 16, men[0]);
        sweep();

        // configuration two: non-contiguous masks, catch-all window
        reg_write(0,  32'h0000_9901);
        reg_write(1,  32'h0000_AA02);
        reg_write(2,  32'h0008_BB03);
        reg_write(3,  32'h003C_CC04);
        reg_write(4,  32'h0100_DD05);
        reg_write(5,  32'h0002_EE06);
        reg_write(6,  32'h0021_FF07);
        reg_write(7,  32'hFFFF_0F0F);
        reg_write(8,  32'h0005_0000);
        reg_write(9,  32'h0030_0000);
        reg_write(10, 32'h0000_0000);
        reg_write(11, 32'h0003_0000);
        reg_write(12, 32'h0000_0000);
        reg_write(13, 32'h0001_0000);
        reg_write(14, 32'h0000_0000);
        reg_write(15, 32'hFFFF_0000);
        a0 = '{2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3};
        a1 = '{2'd3, 2'd2, 2'd3, 2'd1, 2'd3, 2'd0, 2'd3, 2'd1};
        reg_write(16, acc_word(8'h00, a0));
        reg_write(17, acc_word(8'hFB, a1));
        sweep();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule